// File: doc/BRIEF.md
# Grouped Integer Reduction Tree

This block reduces one signed integer value from each of N processing lanes in a single issued operation. The lanes are divided into equal, consecutive groups of a selectable size. Each group is combined through a balanced tree of two-input combiners that computes a sum, a minimum or a maximum. The result of every group is returned together with the index of the lane that receives it.

The lane index is not carried by the operation. The block keeps a target index that moves forward on every issue by the number of groups produced. A software loop that issues reduction after reduction therefore fills successive lanes without reloading the destination. A clear input returns the index to lane zero.

The tree is pipelined with one register per tree level. An input capture register comes first. A valid flag travels with the data and control through the pipeline, so a new operation can be issued every cycle.

Top module: `redux_tree`

## Requirements
- R1: During and after the synchronous active-high reset, `res_valid_o` is 0 and the target index is 0. The first operation issued after reset sends its group 0 result to lane 0.
- R2: An operation sampled with `issue_i` high at clock edge E gives `res_valid_o` high for exactly one cycle, starting just after edge E+log2(N). Operations issued on back-to-back cycles give results on back-to-back cycles, in issue order.
- R3: Group size code c on `gsize_i` selects groups of 2^(c+1) consecutive lanes. Codes past the full width select a single group of all N lanes. Group g covers lanes g·S to g·S+S−1, and its result is placed in slot g, which is bits [g·RW +: RW] of `res_o`. `res_groups_o` equals N/S.
- R4: With `op_i` = 0 or 3, a group result is the signed two's-complement sum of its lanes. The sum is sign-extended to RW = DW + log2(N) bits and never overflows, including the case where every lane holds the most positive or the most negative value.
- R5: `op_i` = 1 returns the signed minimum of the group and `op_i` = 2 returns the signed maximum, sign-extended to RW bits.
- R6: Every result slot g ≥ `res_groups_o` reads zero in `res_o`, and its field in `dest_o` also reads zero.
- R7: The destination of group g is (T+g) mod N, where T is the target index used by that operation. It is placed in bits [g·IW +: IW] of `dest_o`, with IW = log2(N).
- R8: After each issue, the target index becomes (T + number of groups) mod N, so it wraps around the N lanes.
- R9: A high `tgt_clr_i` sets the target index to 0 at that edge. If it comes with an issue, that operation uses T = 0 and the index then advances from 0.
- R10: A cycle without `issue_i` produces no result and leaves the target index unchanged, whether or not `tgt_clr_i` is high, except for the clear described in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Start a reduction with the inputs of this cycle |
| lanes_i | input | N·DW | One signed value per lane, lane i at bits [i·DW +: DW] |
| gsize_i | input | log2(log2 N) | Group size code, size = 2^(code+1) |
| op_i | input | 2 | 0/3 sum, 1 minimum, 2 maximum |
| tgt_clr_i | input | 1 | Return the target index to lane 0 |
| res_valid_o | output | 1 | Result fields are valid this cycle |
| res_o | output | N·RW | Group results, slot g at bits [g·RW +: RW] |
| res_groups_o | output | log2(N)+1 | Number of valid result slots |
| dest_o | output | N·IW | Destination lane for each slot |

## Verification
The bench builds the block with its defaults, N = 16 and DW = 16. This gives a four-level tree, and the two-bit size code then reaches every group size from pairs to all sixteen lanes. The 20-bit result width is just wide enough for the extreme sums of sixteen full-scale lanes, so the all-maximum and all-minimum patterns test the no-overflow bound exactly. With only sixteen target positions, the index wraps within a few issues of each group size, and it wraps in the middle of a group's set of destinations.

// File: rtl/redux_pkg.sv
package redux_pkg;

  typedef enum logic [1:0] {
    RED_SUM     = 2'd0,
    RED_MIN     = 2'd1,
    RED_MAX     = 2'd2,
    RED_SUM_ALT = 2'd3
  } red_op_e;

endpackage

// File: rtl/redux_level.sv
module redux_level
  import redux_pkg::*;
#(
  parameter int N   = 16,
  parameter int RW  = 20,
  parameter int LVL = 1,
  parameter int GLW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  red_op_e         in_op,
  input  logic [GLW-1:0]  in_glog,
  input  logic [N*RW-1:0] in_data,
  output logic            out_valid,
  output red_op_e         out_op,
  output logic [GLW-1:0]  out_glog,
  output logic [N*RW-1:0] out_data
);

  localparam int ACTIVE = N >> LVL;

  logic            merging;
  logic [N*RW-1:0] node;

  // A level merges only while it lies inside the selected group height.
  assign merging = (GLW'(LVL) <= in_glog);

  function automatic logic [RW-1:0] pick(red_op_e op, logic [RW-1:0] a, logic [RW-1:0] b);
    logic signed [RW-1:0] sa;
    logic signed [RW-1:0] sb;
    sa = a;
    sb = b;
    case (op)
      RED_MIN: return (sa < sb) ? a : b;
      RED_MAX: return (sa > sb) ? a : b;
      default: return a + b;
    endcase
  endfunction

  for (genvar j = 0; j < N; j++) begin : g_node
    if (j < ACTIVE) begin : g_comb
      assign node[j*RW +: RW] = merging
        ? pick(in_op, in_data[2*j*RW +: RW], in_data[(2*j+1)*RW +: RW])
        : in_data[j*RW +: RW];
    end else begin : g_tail
      assign node[j*RW +: RW] = merging ? '0 : in_data[j*RW +: RW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_op    <= RED_SUM;
      out_glog  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_op   <= in_op;
        out_glog <= in_glog;
        out_data <= node;
      end
    end
  end

endmodule

// File: rtl/redux_target.sv
module redux_target #(
  parameter int N   = 16,
  parameter int IW  = 4,
  parameter int GLW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic            clr,
  input  logic [GLW-1:0]  glog,
  output logic [N*IW-1:0] dest_q
);

  logic [IW-1:0]   tgt_q;
  logic [IW-1:0]   base;
  logic [IW:0]     groups;
  logic [N*IW-1:0] dest_d;

  assign base   = clr ? '0 : tgt_q;
  assign groups = (IW+1)'(N) >> glog;

  for (genvar g = 0; g < N; g++) begin : g_dest
    assign dest_d[g*IW +: IW] = ((IW+1)'(g) < groups) ? IW'(base + IW'(g)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= '0;
      dest_q <= '0;
    end else if (issue) begin
      tgt_q  <= IW'(base + groups[IW-1:0]);
      dest_q <= dest_d;
    end else if (clr) begin
      tgt_q  <= '0;
    end
  end

endmodule

// File: rtl/redux_tree.sv
module redux_tree
  import redux_pkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 16,
  localparam int L   = $clog2(N),
  localparam int RW  = DW + L,
  localparam int IW  = L,
  localparam int GSW = $clog2(L),
  localparam int GLW = $clog2(L + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_i,
  input  logic [N*DW-1:0] lanes_i,
  input  logic [GSW-1:0]  gsize_i,
  input  logic [1:0]      op_i,
  input  logic            tgt_clr_i,
  output logic            res_valid_o,
  output logic [N*RW-1:0] res_o,
  output logic [IW:0]     res_groups_o,
  output logic [N*IW-1:0] dest_o
);

  logic [GLW-1:0]  glog_in;
  logic [N*RW-1:0] ext;

  always_comb begin
    int unsigned height;
    height  = int'(gsize_i) + 1;
    glog_in = (height > L) ? GLW'(L) : GLW'(height);
  end

  for (genvar i = 0; i < N; i++) begin : g_ext
    assign ext[i*RW +: RW] = {{L{lanes_i[i*DW+DW-1]}}, lanes_i[i*DW +: DW]};
  end

  logic            lv_valid [L+1];
  red_op_e         lv_op    [L+1];
  logic [GLW-1:0]  lv_glog  [L+1];
  logic [N*RW-1:0] lv_data  [L+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lv_valid[0] <= 1'b0;
      lv_op[0]    <= RED_SUM;
      lv_glog[0]  <= '0;
      lv_data[0]  <= '0;
    end else begin
      lv_valid[0] <= issue_i;
      if (issue_i) begin
        lv_op[0]   <= red_op_e'(op_i);
        lv_glog[0] <= glog_in;
        lv_data[0] <= ext;
      end
    end
  end

  for (genvar k = 1; k <= L; k++) begin : g_level
    redux_level #(.N(N), .RW(RW), .LVL(k), .GLW(GLW)) u_level (
      .clk      (clk),
      .rst      (rst),
      .in_valid (lv_valid[k-1]),
      .in_op    (lv_op[k-1]),
      .in_glog  (lv_glog[k-1]),
      .in_data  (lv_data[k-1]),
      .out_valid(lv_valid[k]),
      .out_op   (lv_op[k]),
      .out_glog (lv_glog[k]),
      .out_data (lv_data[k])
    );
  end

  logic [N*IW-1:0] dst_pipe [L+1];

  redux_target #(.N(N), .IW(IW), .GLW(GLW)) u_target (
    .clk   (clk),
    .rst   (rst),
    .issue (issue_i),
    .clr   (tgt_clr_i),
    .glog  (glog_in),
    .dest_q(dst_pipe[0])
  );

  for (genvar k = 1; k <= L; k++) begin : g_dst
    always_ff @(posedge clk) begin
      if (rst) begin
        dst_pipe[k] <= '0;
      end else if (lv_valid[k-1]) begin
        dst_pipe[k] <= dst_pipe[k-1];
      end
    end
  end

  assign res_valid_o  = lv_valid[L];
  assign res_o        = lv_data[L];
  assign res_groups_o = (IW+1)'(N) >> lv_glog[L];
  assign dest_o       = dst_pipe[L];

endmodule

// File: rtl/redux_tree_chk.sv
module redux_tree_chk #(
  parameter int N  = 16,
  parameter int RW = 20,
  parameter int IW = 4,
  parameter int L  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            issue_i,
  input logic            tgt_clr_i,
  input logic            res_valid_o,
  input logic [N*RW-1:0] res_o,
  input logic [IW:0]     res_groups_o,
  input logic [N*IW-1:0] dest_o
);

  logic [L:0] vpipe;
  logic [L:0] cpipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe <= '0;
      cpipe <= '0;
    end else begin
      vpipe <= {vpipe[L-1:0], issue_i};
      cpipe <= {cpipe[L-1:0], issue_i & tgt_clr_i};
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    res_valid_o == vpipe[L]); // R2

  AST_GROUP_COUNT_POW2: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> ($countones(res_groups_o) == 1)); // R3

  AST_CLEAR_DEST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && cpipe[L]) |-> (dest_o[IW-1:0] == '0)); // R9

  AST_DEST_CONSECUTIVE: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && res_groups_o > 1) |-> (dest_o[IW +: IW] == IW'(dest_o[IW-1:0] + IW'(1)))); // R7

  for (genvar j = 1; j < N; j++) begin : g_slot
    AST_UNUSED_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (res_valid_o && (IW+1)'(j) >= res_groups_o) |-> (res_o[j*RW +: RW] == '0 && dest_o[j*IW +: IW] == '0)); // R6
  end

endmodule

bind redux_tree redux_tree_chk #(.N(N), .RW(RW), .IW(IW), .L(L)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_i     (issue_i),
  .tgt_clr_i   (tgt_clr_i),
  .res_valid_o (res_valid_o),
  .res_o       (res_o),
  .res_groups_o(res_groups_o),
  .dest_o      (dest_o)
);

// File: tb/redux_tree_test.sv
module redux_tree_test;

  localparam int N   = 16;
  localparam int DW  = 16;
  localparam int L   = $clog2(N);
  localparam int RW  = DW + L;
  localparam int IW  = L;
  localparam int GSW = $clog2(L);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            issue_i = 1'b0;
  logic [N*DW-1:0] lanes_i = '0;
  logic [GSW-1:0]  gsize_i = '0;
  logic [1:0]      op_i = '0;
  logic            tgt_clr_i = 1'b0;
  logic            res_valid_o;
  logic [N*RW-1:0] res_o;
  logic [IW:0]     res_groups_o;
  logic [N*IW-1:0] dest_o;

  redux_tree #(.N(N), .DW(DW)) uut (
    .clk(clk), .rst(rst), .issue_i(issue_i), .lanes_i(lanes_i),
    .gsize_i(gsize_i), .op_i(op_i), .tgt_clr_i(tgt_clr_i),
    .res_valid_o(res_valid_o), .res_o(res_o),
    .res_groups_o(res_groups_o), .dest_o(dest_o)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [N*RW-1:0] res;
    logic [N*RW-1:0] mask;
    logic [N*IW-1:0] dst;
    logic [IW:0]     groups;
    logic [1:0]      op;
    logic [31:0]     at_edge;
  } exp_t;

  exp_t q[$];
  int   nchk = 0;
  int   nfail = 0;
  int   cyc = 0;
  int   tgt_m = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [N*RW-1:0] act, input logic [N*RW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected item, queues it and presents the operation for one edge.
  task automatic do_issue(input logic [N*DW-1:0] v, input int code, input int op, input bit clr);
    exp_t e;
    int size, groups, base;
    size   = (code + 1 > L) ? N : (1 << (code + 1));
    groups = N / size;
    base   = clr ? 0 : tgt_m;
    e = '0;
    for (int g = 0; g < groups; g++) begin
      logic signed [RW-1:0] acc;
      logic signed [DW-1:0] x;
      x = v[(g*size)*DW +: DW];
      acc = x;
      for (int i = 1; i < size; i++) begin
        logic signed [RW-1:0] y;
        x = v[(g*size+i)*DW +: DW];
        y = x;
        if (op == 1)      acc = (y < acc) ? y : acc;
        else if (op == 2) acc = (y > acc) ? y : acc;
        else              acc = acc + y;
      end
      e.res[g*RW +: RW]  = acc;
      e.mask[g*RW +: RW] = '1;
      e.dst[g*IW +: IW]  = IW'((base + g) % N);
    end
    e.groups  = (IW+1)'(groups);
    e.op      = 2'(op);
    e.at_edge = 32'(cyc + 1);
    tgt_m = (base + groups) % N;
    q.push_back(e);
    issue_i   = 1'b1;
    lanes_i   = v;
    gsize_i   = GSW'(code);
    op_i      = 2'(op);
    tgt_clr_i = clr;
    @(negedge clk);
    issue_i   = 1'b0;
    tgt_clr_i = 1'b0;
  endtask

  task automatic idle(input int n, input bit clr);
    for (int i = 0; i < n; i++) begin
      tgt_clr_i = clr;
      if (clr) tgt_m = 0;
      @(negedge clk);
      tgt_clr_i = 1'b0;
    end
  endtask

  function automatic logic [N*DW-1:0] rand_lanes();
    logic [N*DW-1:0] v;
    for (int i = 0; i < N; i++) v[i*DW +: DW] = DW'($urandom);
    return v;
  endfunction

  function automatic logic [N*DW-1:0] fill(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [N*DW-1:0] v;
    for (int i = 0; i < N; i++) v[i*DW +: DW] = (i % 2 == 0) ? a : b;
    return v;
  endfunction

  // Monitor: pops the oldest expected item whenever a result appears.
  always @(negedge clk) begin
    if (!rst && res_valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 result without issue", (N*RW)'(res_valid_o), '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == int'(e.at_edge) + L, "R2 latency", (N*RW)'(cyc), (N*RW)'(int'(e.at_edge) + L));
        check(res_groups_o == e.groups, "R3 group count", (N*RW)'(res_groups_o), (N*RW)'(e.groups));
        if (e.op == 2'd1 || e.op == 2'd2)
          check((res_o & e.mask) == e.res, "R5 min/max value", res_o & e.mask, e.res);
        else
          check((res_o & e.mask) == e.res, "R3 R4 sum value", res_o & e.mask, e.res);
        check((res_o & ~e.mask) == '0, "R6 unused slots", res_o & ~e.mask, '0);
        check(dest_o == e.dst, "R1 R7 R8 R9 destinations", (N*RW)'(dest_o), (N*RW)'(e.dst));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid_o == 1'b0, "R1 valid low in reset", (N*RW)'(res_valid_o), '0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid_o == 1'b0, "R1 valid low after reset", (N*RW)'(res_valid_o), '0);

    // Every size and operation, issued back to back.
    for (int code = 0; code < 4; code++)
      for (int op = 0; op < 4; op++)
        do_issue(rand_lanes(), code, op, 1'b0);

    // Extremes for the no-overflow bound and signed compares.
    do_issue(fill(16'h7FFF, 16'h7FFF), 3, 0, 1'b0);
    do_issue(fill(16'h8000, 16'h8000), 3, 0, 1'b0);
    do_issue(fill(16'h8000, 16'h7FFF), 0, 1, 1'b0);
    do_issue(fill(16'h7FFF, 16'h8000), 1, 2, 1'b0);
    do_issue(fill(16'h8000, 16'h8000), 2, 2, 1'b0);
    do_issue(fill(16'hFFFF, 16'h0001), 0, 3, 1'b0);

    // R10: idle gap keeps the target index.
    idle(3, 1'b0);
    do_issue(rand_lanes(), 2, 0, 1'b0);
    // R9: clear alone, then clear together with issue.
    idle(2, 1'b1);
    do_issue(rand_lanes(), 1, 1, 1'b0);
    do_issue(rand_lanes(), 3, 2, 1'b0);
    do_issue(rand_lanes(), 0, 0, 1'b1);

    // Random stream with occasional clears (R8 wrap, R9).
    for (int n = 0; n < 40; n++)
      do_issue(rand_lanes(), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0));

    idle(L + 3, 1'b0);
    check(q.size() == 0, "R2 all results returned", (N*RW)'(q.size()), '0);

    // R10: clear pulses without issue give no result.
    for (int i = 0; i < 6; i++) begin
      tgt_clr_i = 1'b1;
      tgt_m = 0;
      @(negedge clk);
      tgt_clr_i = 1'b0;
      check(res_valid_o == 1'b0, "R10 no result without issue", (N*RW)'(res_valid_o), '0);
    end
    do_issue(rand_lanes(), 0, 0, 1'b0);
    idle(L + 3, 1'b0);
    check(q.size() == 0, "R2 final drain", (N*RW)'(q.size()), '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule